// File: doc/BRIEF.md
# SPI Serial Clock and Strobe Generator

This block derives the serial clock of an SPI host from the core clock. It also produces single-cycle strobes that tell a separate shift engine when to put the next bit on the data lines and when to capture an incoming bit. All four clock polarity and phase combinations are supported. A rate divider stretches each SCK half-period to `div + 1` core cycles. An optional full-cycle sampling mode captures each input bit one whole SCK period after it was launched, instead of half a period after. Only single transfer rate is used: in each SCK period, exactly one edge samples data.

The shift engine raises `advance_i` while it wants further edges, and holds enable high for the whole command. Dropping either input ends the run: SCK returns to its idle level and the strobes stop. There is one exception. In full-cycle mode, if the last edge was a sampling edge, one delayed sample strobe is still issued, one half-period later. The mode and divider inputs are captured only while `idle_o` is high, so a command always runs with the settings that were present when it began.

Edges are numbered from the start cycle. That cycle is edge 0. Edge j, for j ≥ 1, occurs `j*(div+1)` core cycles after the start cycle. Odd-numbered edges are leading edges and even-numbered edges are trailing edges. Every output is registered, and each strobe appears in the same cycle as the SCK change it belongs to.

Top module: `spi_sck_gen`

## Requirements
- R1: While running, SCK changes level once every `div+1` core cycles. With a divider of 0 it changes every core cycle.
- R2: While idle, `sck_o` equals the CPOL value presented on the previous cycle: 0 gives a low idle level with positive pulses, and 1 gives a high idle level with negative pulses.
- R3: With CPHA=0, `drive_o` fires in the start cycle (edge 0) and on every trailing edge. Without full-cycle mode, `sample_o` fires on every leading edge.
- R4: With CPHA=1, `drive_o` fires on every leading edge. Without full-cycle mode, `sample_o` fires on every trailing edge.
- R5: With full-cycle mode set, `sample_o` moves to the edge after the one it would otherwise use, which is one SCK period after the launch. SCK and `drive_o` are unchanged.
- R6: In full-cycle mode, if `advance_i` drops while enable stays high and the last edge was a sampling edge, one more `sample_o` fires `div+1` cycles after that edge. Until then `idle_o` stays low and SCK stays at its idle level.
- R7: If enable or `advance_i` is low at a clock edge while running, SCK is at its idle level and `idle_o` is high after that edge, and no strobe fires afterwards (apart from the R6 strobe). A low enable also cancels a pending R6 strobe.
- R8: Changes to `cpol_i`, `cpha_i`, `fullcyc_i` or `div_i` while `idle_o` is low have no effect on any output.
- R9: `first_o` fires only together with the first `drive_o` of a command: in the start cycle for CPHA=0, and on edge 1 for CPHA=1.
- R10: After reset, `idle_o` is high, `sck_o` is low and all strobes are low. While idle, no strobe fires.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Core clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| en_i | input | 1 | Block enable; low forces idle |
| advance_i | input | 1 | Engine requests further edges while high |
| cpol_i | input | 1 | Clock polarity (1 = idle high) |
| cpha_i | input | 1 | Clock phase (1 = drive on leading edge) |
| fullcyc_i | input | 1 | Full-cycle sampling mode |
| div_i | input | DIV_W | Half-period length minus one, in core cycles |
| sck_o | output | 1 | Serial clock |
| drive_o | output | 1 | One-cycle strobe: launch next output bit |
| sample_o | output | 1 | One-cycle strobe: capture input bit |
| first_o | output | 1 | Marks the first drive strobe of a command |
| idle_o | output | 1 | High when no command or pending sample is active |

## Verification
On every cycle, the assertions check the following. Drive strobes line up with SCK changes. Normal-mode sample strobes line up with SCK changes. SCK toggles every cycle when the divider is 0. The idle level follows CPOL, and the settings are frozen while busy. Losing enable forces idle. The exact positions of edges and strobes for every combination of mode and divider, and the delayed final sample after the handshake drops, are shown only by the bench scenarios. The bench compares each output against a per-cycle expectation built from the edge numbering.

// File: rtl/sckgen_pkg.sv
package sckgen_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_RUN   = 2'd1,
    ST_DRAIN = 2'd2
  } gen_state_e;

  typedef struct packed {
    logic pol;
    logic pha;
    logic full;
  } mode_t;

endpackage

// File: rtl/sck_prescaler.sv
module sck_prescaler #(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cnt_en_i,
  input  logic             clear_i,
  input  logic [DIV_W-1:0] limit_i,
  output logic             tick_o
);

  logic [DIV_W-1:0] cnt_q, cnt_d;

  assign tick_o = (cnt_q == limit_i);

  always_comb begin
    cnt_d = cnt_q;
    if (clear_i) begin
      cnt_d = '0;
    end else if (cnt_en_i) begin
      cnt_d = tick_o ? '0 : cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (clear_i || cnt_en_i) begin
      cnt_q <= cnt_d;
    end
  end

endmodule

// File: rtl/sck_phase.sv
module sck_phase (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_next_i,
  input  logic edge_go_i,
  output logic lvl_o,
  output logic lead_o,
  output logic trail_o
);

  logic lvl_q, lvl_d;

  assign lead_o  = edge_go_i & ~lvl_q;
  assign trail_o = edge_go_i &  lvl_q;
  assign lvl_o   = lvl_q;

  always_comb begin
    lvl_d = 1'b0;
    if (run_next_i) begin
      lvl_d = lvl_q ^ edge_go_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      lvl_q <= 1'b0;
    end else begin
      lvl_q <= lvl_d;
    end
  end

endmodule

// File: rtl/sck_strobes.sv
module sck_strobes
  import sckgen_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  mode_t mode_i,
  input  logic  start_i,
  input  logic  lead_i,
  input  logic  trail_i,
  input  logic  drain_fire_i,
  input  logic  hold_i,
  output logic  pend_o,
  output logic  drive_o,
  output logic  sample_o,
  output logic  first_o
);

  logic drive_ev, norm_ev, full_ev, samp_ev, first_ev;
  logic pend_q, pend_d, launched_q, launched_d;
  logic drive_q, sample_q, first_q;

  always_comb begin
    drive_ev = mode_i.pha ? lead_i : (start_i | trail_i);
    norm_ev  = mode_i.pha ? trail_i : lead_i;
    full_ev  = pend_q & (lead_i | trail_i | drain_fire_i);
    samp_ev  = mode_i.full ? full_ev : norm_ev;
    first_ev = drive_ev & ~launched_q;
  end

  always_comb begin
    pend_d     = pend_q;
    launched_d = launched_q | drive_ev;
    if (!hold_i) begin
      pend_d     = 1'b0;
      launched_d = 1'b0;
    end else if (mode_i.full && norm_ev) begin
      pend_d = 1'b1;
    end else if (full_ev) begin
      pend_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pend_q     <= 1'b0;
      launched_q <= 1'b0;
      drive_q    <= 1'b0;
      sample_q   <= 1'b0;
      first_q    <= 1'b0;
    end else begin
      pend_q     <= pend_d;
      launched_q <= launched_d;
      drive_q    <= drive_ev;
      sample_q   <= samp_ev;
      first_q    <= first_ev;
    end
  end

  assign pend_o   = pend_q;
  assign drive_o  = drive_q;
  assign sample_o = sample_q;
  assign first_o  = first_q;

  AST_PEND_NEEDS_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (pend_q && hold_i && !drain_fire_i && !(lead_i | trail_i)) |=> pend_q) // R6
    else $error("pending full-cycle sample lost");

endmodule

// File: rtl/spi_sck_gen.sv
module spi_sck_gen
  import sckgen_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  logic             advance_i,
  input  logic             cpol_i,
  input  logic             cpha_i,
  input  logic             fullcyc_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             sck_o,
  output logic             drive_o,
  output logic             sample_o,
  output logic             first_o,
  output logic             idle_o
);

  logic [1:0]       rst_sync_q;
  logic             rst_n;
  gen_state_e       st_q, st_d;
  mode_t            mode_q, mode_eff;
  logic [DIV_W-1:0] div_q, div_eff;
  logic             run, start, tick, edge_go, drain_fire, pend;
  logic             cnt_en, lvl, lead, trail, hold;

  // reset: asserts at once, releases after two clock edges
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_n = rst_sync_q[1];

  assign run      = en_i & advance_i;
  assign start    = (st_q == ST_IDLE) & run;
  assign mode_eff = (st_q == ST_IDLE) ? mode_t'({cpol_i, cpha_i, fullcyc_i}) : mode_q;
  assign div_eff  = (st_q == ST_IDLE) ? div_i : div_q;

  // settings are captured only while idle
  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0;
      div_q  <= '0;
    end else if (st_q == ST_IDLE) begin
      mode_q <= mode_eff;
      div_q  <= div_eff;
    end
  end

  assign edge_go    = (st_q == ST_RUN) & run & tick;
  assign drain_fire = en_i & pend & mode_eff.full & tick &
                      (((st_q == ST_RUN) & ~advance_i) | (st_q == ST_DRAIN));
  assign cnt_en     = en_i & (st_q != ST_IDLE);

  always_comb begin
    st_d = st_q;
    unique case (st_q)
      ST_IDLE:  if (run) st_d = ST_RUN;
      ST_RUN:   if (!run) st_d = (en_i & pend & mode_eff.full & ~tick) ? ST_DRAIN : ST_IDLE;
      ST_DRAIN: if (!en_i || tick) st_d = ST_IDLE;
      default:  st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  assign hold = (st_d != ST_IDLE);

  sck_prescaler #(.DIV_W(DIV_W)) i_prescaler (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .cnt_en_i (cnt_en),
    .clear_i  (start),
    .limit_i  (div_eff),
    .tick_o   (tick)
  );

  sck_phase i_phase (
    .clk_i      (clk_i),
    .rst_ni     (rst_n),
    .run_next_i (st_d == ST_RUN),
    .edge_go_i  (edge_go),
    .lvl_o      (lvl),
    .lead_o     (lead),
    .trail_o    (trail)
  );

  sck_strobes i_strobes (
    .clk_i        (clk_i),
    .rst_ni       (rst_n),
    .mode_i       (mode_eff),
    .start_i      (start),
    .lead_i       (lead),
    .trail_i      (trail),
    .drain_fire_i (drain_fire),
    .hold_i       (hold),
    .pend_o       (pend),
    .drive_o      (drive_o),
    .sample_o     (sample_o),
    .first_o      (first_o)
  );

  assign sck_o  = mode_q.pol ^ lvl;
  assign idle_o = (st_q == ST_IDLE);

  AST_DIV0_TOGGLE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (st_q == ST_RUN && run && div_q == '0) |=> (sck_o != $past(sck_o))) // R1
    else $error("SCK failed to toggle at divider 0");

  AST_IDLE_LEVEL: assert property (@(posedge clk_i) disable iff (!rst_n)
    ($past(rst_n) && idle_o && $past(idle_o)) |-> (sck_o == $past(cpol_i))) // R2
    else $error("idle SCK level differs from CPOL");

  AST_DRIVE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (drive_o && !(first_o && !mode_q.pha)) |-> (sck_o != $past(sck_o))) // R3
    else $error("drive strobe without SCK edge");

  AST_SAMPLE_ON_EDGE: assert property (@(posedge clk_i) disable iff (!rst_n)
    (sample_o && !mode_q.full) |-> (sck_o != $past(sck_o))) // R4
    else $error("half-cycle sample strobe without SCK edge");

  AST_EN_OFF: assert property (@(posedge clk_i) disable iff (!rst_n)
    !$past(en_i) |-> (idle_o && !drive_o && !sample_o)) // R7
    else $error("activity after enable dropped");

  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (!rst_n)
    (!idle_o && !$past(idle_o)) |-> ($stable(mode_q) && $stable(div_q))) // R8
    else $error("settings changed while busy");

  AST_FIRST_AT_START: assert property (@(posedge clk_i) disable iff (!rst_n)
    (first_o && !mode_q.pha) |-> $past(idle_o)) // R9
    else $error("first strobe not at start for CPHA=0");

  AST_IDLE_QUIET: assert property (@(posedge clk_i) disable iff (!rst_n)
    idle_o |-> (!drive_o && !first_o)) // R10
    else $error("drive strobe while idle");

endmodule

// File: tb/test_spi_sck_gen.sv
module test_spi_sck_gen;

  localparam int CLK_PERIOD = 10;
  localparam int DIV_W      = 8;

  logic             clk = 1'b0;
  logic             rst_n;
  logic             en, adv, cpol, cpha, full;
  logic [DIV_W-1:0] div;
  logic             sck, drv, smp, first, idle;

  int n_run  = 0;
  int n_fail = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  spi_sck_gen #(.DIV_W(DIV_W)) i_spi_sck_gen (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .en_i      (en),
    .advance_i (adv),
    .cpol_i    (cpol),
    .cpha_i    (cpha),
    .fullcyc_i (full),
    .div_i     (div),
    .sck_o     (sck),
    .drive_o   (drv),
    .sample_o  (smp),
    .first_o   (first),
    .idle_o    (idle)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    n_run++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: act=%0d exp=%0d", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_drive(bit pha, int j);
    return pha ? (j % 2 == 1) : (j % 2 == 0);
  endfunction

  function automatic bit exp_sample(bit pha, bit fc, int j);
    if (j < 1) return 1'b0;
    if (!fc) return pha ? (j % 2 == 0) : (j % 2 == 1);
    return (j >= 2) && (pha ? (j % 2 == 1) : (j % 2 == 0));
  endfunction

  // one command: nedges SCK edges, then the handshake (or enable) drops
  task automatic run_cmd(input bit pol, input bit pha, input bit fc, input int dv,
                         input int nedges, input bit en_drop, input bit flip);
    int h, last, cd;
    bit drain;
    h     = dv + 1;
    last  = nedges * h;
    drain = !en_drop && fc && (pha ? (nedges % 2 == 0) : (nedges % 2 == 1));
    cd    = (nedges + 1) * h;
    @(negedge clk);
    en = 1'b1; adv = 1'b0; cpol = pol; cpha = pha; full = fc; div = DIV_W'(dv);
    repeat (2) @(negedge clk);
    adv = 1'b1;
    for (int c = 0; c <= cd + 2; c++) begin
      int j;
      bit on, e_sck, e_drv, e_smp, e_first, e_idle;
      string tag;
      @(negedge clk);
      j  = c / h;
      on = (c % h == 0);
      if (c <= last) begin
        e_sck   = pol ^ j[0];
        e_drv   = on && exp_drive(pha, j);
        e_smp   = on && exp_sample(pha, fc, j);
        e_first = on && (pha ? (j == 1) : (j == 0));
        e_idle  = 1'b0;
      end else begin
        e_sck   = pol;
        e_drv   = 1'b0;
        e_first = 1'b0;
        e_smp   = drain && (c == cd);
        e_idle  = drain ? (c >= cd) : 1'b1;
      end
      if (flip && c >= 1 && c <= last) tag = "R8";
      else tag = "";
      chk(tag == "" ? "R1" : tag, "sck", sck, e_sck);
      chk(tag == "" ? (pha ? "R4" : "R3") : tag, "drive", drv, e_drv);
      chk(tag == "" ? (c > last ? (drain ? "R6" : "R7") : (fc ? "R5" : (pha ? "R4" : "R3"))) : tag,
          "sample", smp, e_smp);
      chk(tag == "" ? "R9" : tag, "first", first, e_first);
      chk(tag == "" ? (c > last ? (drain ? "R6" : "R7") : "R10") : tag, "idle", idle, e_idle);
      // inputs for the next edge c+1
      if (en_drop) en = (c + 1 <= last);
      else adv = (c + 1 <= last);
      if (en_drop && c + 1 > last) adv = 1'b0;
      if (flip && (c + 1) < last) begin
        cpol = 1'($urandom); cpha = 1'($urandom); full = 1'($urandom);
        div  = DIV_W'($urandom_range(0, 7));
      end else begin
        cpol = pol; cpha = pha; full = fc; div = DIV_W'(dv);
      end
    end
    en = 1'b1;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fail++;
      $display("FAIL watchdog: act=%0d exp=%0d", 0, 1);
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd5150));
    rst_n = 1'b0; en = 1'b0; adv = 1'b0; cpol = 1'b0; cpha = 1'b0; full = 1'b0; div = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R10: reset state
    chk("R10", "sck", sck, 0);
    chk("R10", "drive", drv, 0);
    chk("R10", "sample", smp, 0);
    chk("R10", "first", first, 0);
    chk("R10", "idle", idle, 1);
    // R2: idle level follows CPOL
    cpol = 1'b1;
    repeat (2) @(negedge clk);
    chk("R2", "sck idle high", sck, 1);
    cpol = 1'b0;
    repeat (2) @(negedge clk);
    chk("R2", "sck idle low", sck, 0);
    // directed corners: all modes at full speed
    for (int m = 0; m < 8; m++) run_cmd(m[2], m[1], m[0], 0, 8, 1'b0, 1'b0);
    run_cmd(1'b0, 1'b0, 1'b1, 0, 1, 1'b0, 1'b0);   // R6 single edge, drain
    run_cmd(1'b0, 1'b1, 1'b1, 2, 1, 1'b0, 1'b0);   // no sample pending
    run_cmd(1'b1, 1'b1, 1'b1, 3, 4, 1'b0, 1'b0);   // R6 drain, slow
    run_cmd(1'b0, 1'b0, 1'b1, 3, 5, 1'b1, 1'b0);   // R7 enable cancels drain
    run_cmd(1'b1, 1'b0, 1'b0, 20, 3, 1'b0, 1'b1);  // R8 with large divider
    // random mix
    for (int k = 0; k < 40; k++) begin
      run_cmd(1'($urandom), 1'($urandom), 1'($urandom), $urandom_range(0, 3),
              $urandom_range(1, 17), ($urandom_range(0, 4) == 0), ($urandom_range(0, 2) == 0));
    end
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

endmodule